// File: doc/BRIEF.md
# Camera Sample Word Packer

This block sits between a camera-side capture port and the write side of a 32-bit FIFO. Each clock in which the source marks a sample valid, and the block is ready, one sample is taken from a 16-bit input bus. Samples are collected into 32-bit words, with the first sample of a word in the low lane. A completed word is offered on a valid/ready output port.

Two packing modes exist. In narrow mode, only an 8-bit component is kept from each sample, taken from bits [9:2] of the bus, so a 10-bit source on bits [9:0] loses its two low bits. Four such bytes make a word. In wide mode, the whole 16-bit sample is kept, for example luma plus one chroma component of a 4:2:2 stream. Two such samples make a word. The mode is captured only when a frame starts. A frame start also discards any partly filled word, so that no word carries samples from two frames. A one-entry output register holds a finished word until the downstream side accepts it. While that word is stalled, the input is held off.

Top module: `pix_pack_bridge`

## Requirements
- R1: After reset, `word_valid_o` is low and `smp_ready_o` is high.
- R2: In narrow mode (mode value 0), four accepted samples form one word. Each contributes its bits [9:2]; bits [15:10] and [1:0] have no effect. The earliest sample lands in word bits [7:0], and the following ones in [15:8], [23:16] and [31:24].
- R3: In wide mode (mode value 1), two accepted samples form one word. The first sample's bits [15:0] land in word bits [15:0], and the second's in [31:16].
- R4: The packing mode is the value of `mode_i` in a cycle where `frame_start_i` is high. Changes of `mode_i` at other times have no effect until the next frame start. Before the first frame start, narrow mode applies.
- R5: A frame start discards a partly filled word and restarts at the lowest lane. A sample accepted in the same cycle as a frame start is the first sample of the new frame and uses the new mode.
- R6: While `word_valid_o` is high and `word_ready_i` is low, `word_o` and `word_valid_o` hold, `smp_ready_o` is low, and no sample is lost.
- R7: Each completed word is presented for exactly one accepted output transfer, with no duplicates and no omissions.
- R8: `word_valid_o` rises on the clock edge that accepts the sample completing a word.
- R9: Cycles with `smp_valid_i` low do not advance packing, whatever the value on the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame start strobe; captures the mode and restarts packing |
| mode_i | input | 1 | Packing mode: 0 keeps 8 bits per sample, 1 keeps 16 bits |
| smp_valid_i | input | 1 | Input sample valid |
| smp_data_i | input | 16 | Input sample bus |
| smp_ready_o | output | 1 | Block can take a sample this cycle |
| word_o | output | 32 | Packed output word |
| word_valid_o | output | 1 | Output word valid |
| word_ready_i | input | 1 | Downstream can take the word |

## Verification
A wrong lane counter shows up at the ports as bytes rotated or shifted within the very next completed word. It also makes words complete one or more samples early or late, which breaks the expected word order from that point on. A mode latched at the wrong time changes the word width after at most two samples. A lost or duplicated word under backpressure misaligns the scoreboard at the next output transfer. A held word that changes while stalled is caught on the following stalled cycle.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;

    typedef enum logic {
        PACK_NARROW = 1'b0,
        PACK_WIDE   = 1'b1
    } pack_mode_e;

endpackage

// File: rtl/pix_lane_select.sv
module pix_lane_select
    import pix_pack_pkg::*;
#(
    parameter int IN_W       = 16,
    parameter int OUT_W      = 32,
    parameter int NARROW_W   = 8,
    parameter int NARROW_LSB = 2
) (
    input  pack_mode_e                                     mode_i,
    input  logic [$clog2(OUT_W/NARROW_W)-1:0]             lane_i,
    input  logic [IN_W-1:0]                                data_i,
    output logic [OUT_W-1:0]                               ins_mask_o,
    output logic [OUT_W-1:0]                               ins_bits_o,
    output logic                                           last_o
);
    localparam int N_NARROW = OUT_W / NARROW_W;
    localparam int N_WIDE   = OUT_W / IN_W;
    localparam int LANE_W   = $clog2(N_NARROW);

    logic [OUT_W-1:0] narrow_mask, narrow_bits;
    logic [OUT_W-1:0] wide_mask, wide_bits;

    for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
        assign narrow_mask[g*NARROW_W +: NARROW_W] = {NARROW_W{lane_i == LANE_W'(g)}};
        assign narrow_bits[g*NARROW_W +: NARROW_W] = data_i[NARROW_LSB +: NARROW_W];
    end

    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        assign wide_mask[g*IN_W +: IN_W] = {IN_W{lane_i == LANE_W'(g)}};
        assign wide_bits[g*IN_W +: IN_W] = data_i;
    end

    always_comb begin
        if (mode_i == PACK_WIDE) begin
            ins_mask_o = wide_mask;
            ins_bits_o = wide_bits;
            last_o     = (lane_i == LANE_W'(N_WIDE - 1));
        end else begin
            ins_mask_o = narrow_mask;
            ins_bits_o = narrow_bits;
            last_o     = (lane_i == LANE_W'(N_NARROW - 1));
        end
    end

endmodule

// File: rtl/pix_word_accum.sv
module pix_word_accum
    import pix_pack_pkg::*;
#(
    parameter int IN_W       = 16,
    parameter int OUT_W      = 32,
    parameter int NARROW_W   = 8,
    parameter int NARROW_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  pack_mode_e        mode_i,
    input  logic              accept_i,
    input  logic [IN_W-1:0]   data_i,
    output logic [OUT_W-1:0]  word_o,
    output logic              done_o
);
    localparam int N_NARROW = OUT_W / NARROW_W;
    localparam int N_WIDE   = OUT_W / IN_W;
    localparam int LANE_W   = $clog2(N_NARROW);

    typedef struct packed {
        logic [OUT_W-1:0]  acc;
        logic [LANE_W-1:0] lane;
        pack_mode_e        mode;
    } acc_state_t;

    acc_state_t st_d, st_q;

    pack_mode_e        mode_eff;
    logic [LANE_W-1:0] lane_eff;
    logic [OUT_W-1:0]  acc_eff;
    logic [OUT_W-1:0]  ins_mask, ins_bits, merged;
    logic              is_last;

    pix_lane_select #(
        .IN_W       (IN_W),
        .OUT_W      (OUT_W),
        .NARROW_W   (NARROW_W),
        .NARROW_LSB (NARROW_LSB)
    ) u_sel (
        .mode_i     (mode_eff),
        .lane_i     (lane_eff),
        .data_i     (data_i),
        .ins_mask_o (ins_mask),
        .ins_bits_o (ins_bits),
        .last_o     (is_last)
    );

    always_comb begin
        mode_eff = frame_start_i ? mode_i : st_q.mode;
        lane_eff = frame_start_i ? '0 : st_q.lane;
        acc_eff  = frame_start_i ? '0 : st_q.acc;
        merged   = (acc_eff & ~ins_mask) | (ins_bits & ins_mask);

        st_d.mode = mode_eff;
        st_d.lane = lane_eff;
        st_d.acc  = acc_eff;
        if (accept_i) begin
            if (is_last) begin
                st_d.lane = '0;
                st_d.acc  = '0;
            end else begin
                st_d.lane = lane_eff + LANE_W'(1);
                st_d.acc  = merged;
            end
        end

        word_o = merged;
        done_o = accept_i && is_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{acc: '0, lane: '0, mode: PACK_NARROW};
        end else begin
            st_q <= st_d;
        end
    end

    // R3: in wide mode the lane index never passes the second lane
    assert_lane_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PACK_WIDE) |-> (st_q.lane < LANE_W'(N_WIDE)));

    // R5: a frame start with no sample leaves packing at the lowest lane
    assert_frame_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && !accept_i) |=> (st_q.lane == '0));

    // R4: the latched mode moves only on a frame start
    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> (st_q.mode == $past(st_q.mode)));

endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage #(
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OUT_W-1:0] word_i,
    output logic [OUT_W-1:0] word_o,
    output logic             valid_o,
    input  logic             ready_i,
    output logic             can_load_o
);
    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             valid;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.word  = word_i;
            st_d.valid = 1'b1;
        end else if (ready_i) begin
            st_d.valid = 1'b0;
        end
        can_load_o = !st_q.valid || ready_i;
        word_o     = st_q.word;
        valid_o    = st_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{word: '0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a new word is never loaded over one that is still stalled
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!valid_o || ready_i));

    // R6: a stalled word stays put
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(word_o)));

endmodule

// File: rtl/pix_pack_bridge.sv
module pix_pack_bridge
    import pix_pack_pkg::*;
#(
    parameter int IN_W       = 16,
    parameter int OUT_W      = 32,
    parameter int NARROW_W   = 8,
    parameter int NARROW_LSB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             mode_i,
    input  logic             smp_valid_i,
    input  logic [IN_W-1:0]  smp_data_i,
    output logic             smp_ready_o,
    output logic [OUT_W-1:0] word_o,
    output logic             word_valid_o,
    input  logic             word_ready_i
);
    logic             accept;
    logic             done;
    logic             can_load;
    logic [OUT_W-1:0] packed_word;

    assign smp_ready_o = can_load;
    assign accept      = smp_valid_i && can_load;

    pix_word_accum #(
        .IN_W       (IN_W),
        .OUT_W      (OUT_W),
        .NARROW_W   (NARROW_W),
        .NARROW_LSB (NARROW_LSB)
    ) u_accum (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .mode_i        (pack_mode_e'(mode_i)),
        .accept_i      (accept),
        .data_i        (smp_data_i),
        .word_o        (packed_word),
        .done_o        (done)
    );

    pix_out_stage #(
        .OUT_W (OUT_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (done),
        .word_i     (packed_word),
        .word_o     (word_o),
        .valid_o    (word_valid_o),
        .ready_i    (word_ready_i),
        .can_load_o (can_load)
    );

    // R6: input is held off while the output is stalled
    assert_stall_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && !word_ready_i) |-> !smp_ready_o);

    // R8: a word appears only right after an accepted sample
    assert_word_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid_o) |-> $past(smp_valid_i && smp_ready_o));

endmodule

// File: tb/tb_pix_pack_bridge.sv
module tb_pix_pack_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [15:0] smp_data_i = '0;
    logic        smp_ready_o;
    logic [31:0] word_o;
    logic        word_valid_o;
    logic        word_ready_i = 1'b1;

    always #4 clk = ~clk;

    pix_pack_bridge dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .mode_i        (mode_i),
        .smp_valid_i   (smp_valid_i),
        .smp_data_i    (smp_data_i),
        .smp_ready_o   (smp_ready_o),
        .word_o        (word_o),
        .word_valid_o  (word_valid_o),
        .word_ready_i  (word_ready_i)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R2";

    logic        m_mode = 1'b0;
    int          m_lane = 0;
    logic [31:0] m_acc  = '0;

    logic        rdy_auto = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic [15:0] junk = 16'h1357;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_add(input logic [15:0] d);
        if (!m_mode) begin
            m_acc[8*m_lane +: 8] = d[9:2];
            m_lane++;
            if (m_lane == 4) begin
                exp_q.push_back(m_acc); tag_q.push_back(cur_tag);
                m_lane = 0; m_acc = '0;
            end
        end else begin
            m_acc[16*m_lane +: 16] = d;
            m_lane++;
            if (m_lane == 2) begin
                exp_q.push_back(m_acc); tag_q.push_back(cur_tag);
                m_lane = 0; m_acc = '0;
            end
        end
    endtask

    task automatic wait_accept();
        forever begin
            #1;
            if (smp_ready_o) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_start_i = 1'b0;
            smp_valid_i   = 1'b0;
            junk          = {junk[14:0], junk[15] ^ junk[13]};
            smp_data_i    = junk;  // R9: garbage on the bus while not valid
            @(posedge clk);
        end
    endtask

    task automatic send(input logic [15:0] d, input int gap);
        if (gap > 0) idle(gap);
        @(negedge clk);
        frame_start_i = 1'b0;
        smp_valid_i   = 1'b1;
        smp_data_i    = d;
        wait_accept();
        model_add(d);
    endtask

    task automatic frame(input logic m, input bit with_smp, input logic [15:0] d);
        @(negedge clk);
        frame_start_i = 1'b1;
        mode_i        = m;
        smp_valid_i   = with_smp;
        smp_data_i    = d;
        m_mode = m; m_lane = 0; m_acc = '0;
        if (with_smp) begin
            wait_accept();
            model_add(d);
        end else begin
            @(posedge clk);
        end
    endtask

    // random-ish downstream ready
    always @(negedge clk) begin
        if (rdy_auto) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            word_ready_i = lfsr[0] | lfsr[1];
        end
    end

    // scoreboard monitor
    bit          stall_prev = 1'b0;
    logic [31:0] held = '0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (stall_prev)
                chk(word_valid_o && (word_o == held), "R6", word_o, held);
            if (word_valid_o && word_ready_i) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", word_o, 32'hx);
                end else begin
                    logic [31:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(word_o == e, t, word_o, e);
                end
            end
            stall_prev = word_valid_o && !word_ready_i;
            held       = word_o;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(word_valid_o == 1'b0, "R1", 32'(word_valid_o), 32'd0);
        chk(smp_ready_o == 1'b1, "R1", 32'(smp_ready_o), 32'd1);

        // R4: no frame start yet, mode_i high still packs narrow
        cur_tag = "R4";
        mode_i  = 1'b1;
        for (int i = 0; i < 8; i++) send(16'hFC03 ^ 16'(i * 16'h0104), 0);
        idle(3);

        // R2 and R9: narrow mode, junk in unused bits and idle gaps
        cur_tag = "R2";
        frame(1'b0, 1'b0, '0);
        for (int i = 0; i < 12; i++) send({6'(i * 5), 8'(8'h11 * i + 3), 2'(i)}, i % 3);
        idle(3);

        // R3 and R4: wide mode, mode_i flips mid-frame without effect
        cur_tag = "R3";
        frame(1'b1, 1'b0, '0);
        for (int i = 0; i < 6; i++) begin
            if (i == 3) mode_i = 1'b0;
            send(16'hA000 + 16'(i * 16'h0111), i % 2);
        end
        idle(3);

        // R5: partial narrow word dropped, frame start carries first wide sample
        cur_tag = "R5";
        frame(1'b0, 1'b0, '0);
        for (int i = 0; i < 3; i++) send(16'h00F0 + 16'(i), 0);
        frame(1'b1, 1'b1, 16'hBEEF);
        send(16'hCAFE, 0);
        idle(3);
        chk(exp_q.size() == 0, "R5", 32'(exp_q.size()), 32'd0);

        // R8: word valid appears right after the completing sample
        cur_tag = "R8";
        send(16'h1234, 0);
        #3 chk(word_valid_o == 1'b0, "R8", 32'(word_valid_o), 32'd0);
        send(16'h5678, 0);
        #3 chk(word_valid_o == 1'b1, "R8", 32'(word_valid_o), 32'd1);
        idle(2);

        // R6: stall holds the word and blocks input, nothing lost
        cur_tag = "R6";
        frame(1'b0, 1'b0, '0);
        @(negedge clk);
        word_ready_i = 1'b0;
        for (int i = 0; i < 4; i++) send(16'h0300 + 16'(i * 4), 0);
        idle(1);
        @(negedge clk);
        #2 chk(smp_ready_o == 1'b0, "R6", 32'(smp_ready_o), 32'd0);
        fork
            begin
                for (int i = 0; i < 4; i++) send(16'h0200 + 16'(i * 8), 0);
            end
            begin
                repeat (5) @(negedge clk);
                word_ready_i = 1'b1;
            end
        join
        idle(4);

        // R7: long streams under random backpressure, both modes
        cur_tag = "R7";
        rdy_auto = 1'b1;
        frame(1'b1, 1'b0, '0);
        for (int i = 0; i < 40; i++) send(16'(i * 16'h0931 + 7), i % 4 == 0 ? 1 : 0);
        frame(1'b0, 1'b1, 16'h03FC);
        for (int i = 0; i < 39; i++) send(16'(i * 16'h1263 + 1), i % 5 == 0 ? 1 : 0);
        rdy_auto = 1'b0;
        @(negedge clk);
        word_ready_i = 1'b1;
        idle(6);
        chk(exp_q.size() == 0, "R7", 32'(exp_q.size()), 32'd0);
        chk(word_valid_o == 1'b0, "R7", 32'(word_valid_o), 32'd0);

        summary();
    end

endmodule